// File: doc/BRIEF.md
# Mesh Neighbour Link Port

This unit sits inside one tile of a two-dimensional grid of small processor cores and gives that core direct word-wide channels to the tiles above, below, left and right of it. Each side has an outbound channel and an inbound channel. Each channel carries a 32-bit data word and one valid bit. A backpressure bit runs the other way and reports whether the receiving tile can take a word. The grid has no wraparound, so the sides of a tile on the edge of the grid are left unconnected. The parameter `CONNECTED` marks which sides have a neighbour.

The core reaches the unit only through explicit send and receive operations, in the third of its five pipeline stages. The unit keeps a one-word outbound slot and a one-word inbound slot for every side. A send writes the word into the outbound slot for its side. The word then waits on the link until the neighbour reports room. A receive takes the word held in the inbound slot for its side. If the operation cannot complete in this cycle, the unit raises a stall and the pipeline presents the same operation again. A send stalls when the outbound slot is occupied, and a receive stalls when the inbound slot is empty. Operations addressed to an unconnected side complete at once and return zero, so a program that runs on an edge tile cannot hang. The unit does not route or forward words; each word moves exactly one hop.

Top module: `mesh_link_unit`

## Requirements
- R1: While reset is asserted and just after it is released, every `tx_vld_o` bit is 0, `stall_o` is 0, and `rx_room_o` equals `CONNECTED` (every connected side can accept a word).
- R2: A send (`op_vld_i`=1, `op_send_i`=1) to a connected side whose outbound slot is empty does not stall. From the next cycle on, `tx_vld_o[d]` is 1 and `tx_data_o[d*32 +: 32]` carries the word. Side numbering: 0 north, 1 east, 2 south, 3 west.
- R3: An outbound word and its valid bit stay unchanged while `tx_room_i[d]` is 0. If `tx_vld_o[d]` and `tx_room_i[d]` are both 1 at a clock edge, the word has transferred, and `tx_vld_o[d]` is 0 after that edge unless a new send was accepted.
- R4: A send to a connected side whose outbound slot is still occupied raises `stall_o`, and the held word is not changed.
- R5: An inbound word is captured at a clock edge where `rx_vld_i[d]`=1 and `rx_room_o[d]`=1. After that edge `rx_room_o[d]` is 0, and further inbound words on that side are ignored until the core reads the slot.
- R6: A receive (`op_send_i`=0) from a side whose inbound slot is full returns the held word on `op_rdata_o` in the same cycle without stalling. `rx_room_o[d]` returns to 1 after that edge.
- R7: A receive from a connected side whose inbound slot is empty raises `stall_o` and drives `op_rdata_o` to 0.
- R8: On a side whose `CONNECTED` bit is 0, sends and receives never stall and return `op_rdata_o`=0. `tx_vld_o` and `rx_room_o` for that side stay 0, and inbound valid words on that side are ignored.
- R9: The sides are independent. A full or stalled slot on one side does not prevent a send or receive on another side, and does not change that side's slots.
- R10: With `op_vld_i`=0, `stall_o` is 0 and `op_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld_i | input | 1 | A link operation is in the exchange stage |
| op_send_i | input | 1 | 1 = send, 0 = receive |
| op_dir_i | input | 2 | Side addressed: 0 north, 1 east, 2 south, 3 west |
| op_wdata_i | input | 32 | Word to send |
| stall_o | output | 1 | Operation cannot complete this cycle; hold the pipeline |
| op_rdata_o | output | 32 | Word returned by a receive, 0 otherwise |
| tx_data_o | output | 128 | Outbound words, side d at bits d*32 +: 32 |
| tx_vld_o | output | 4 | Outbound valid bit per side |
| tx_room_i | input | 4 | Neighbour can accept a word, per side |
| rx_data_i | input | 128 | Inbound words, side d at bits d*32 +: 32 |
| rx_vld_i | input | 4 | Inbound valid bit per side |
| rx_room_o | output | 4 | Inbound slot empty, per side |

## Verification
A table of words is sent and then received on each connected side. The table mixes all-zero, all-one, alternating and single-high-bit patterns, so a swapped side, a misplaced slice or a stuck data bit in either direction shows up as a wrong word. Directed cases follow. A neighbour that holds back its room bit shows whether the outbound word is held or lost. A second send into an occupied slot, and a receive from an empty one, must stall. A second inbound word sent while the slot is full must not overwrite the first. A busy side must leave a neighbouring side usable. The bench ties one side off as an edge, which separates the immediate zero-returning completion on that side from a real stall on a connected side.

// File: rtl/mesh_link_pkg.sv
package mesh_link_pkg;
  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam int unsigned LINK_WORD_W = 32;
  localparam int unsigned LINK_SIDES  = 4;
endpackage

// File: rtl/mesh_tx_slot.sv
module mesh_tx_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          link_vld,
  output logic [DW-1:0] link_data,
  input  logic          link_room
);
  logic          vld_q, vld_d;
  logic [DW-1:0] data_q;

  always_comb begin
    vld_d = vld_q;
    if (vld_q && link_room) vld_d = 1'b0;
    if (wr_en)              vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q <= wr_data;
  end

  assign full      = vld_q;
  assign link_vld  = vld_q;
  assign link_data = data_q;
endmodule

// File: rtl/mesh_rx_slot.sv
module mesh_rx_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_vld,
  input  logic [DW-1:0] link_data,
  output logic          link_room,
  input  logic          rd_en,
  output logic          has_data,
  output logic [DW-1:0] rd_data
);
  logic          vld_q, vld_d;
  logic [DW-1:0] data_q;
  logic          capture;

  assign capture = link_vld && !vld_q;

  always_comb begin
    vld_d = vld_q;
    if (rd_en)   vld_d = 1'b0;
    if (capture) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (capture) data_q <= link_data;
  end

  assign link_room = !vld_q;
  assign has_data  = vld_q;
  assign rd_data   = data_q;
endmodule

// File: rtl/mesh_op_decode.sv
module mesh_op_decode #(
  parameter int                NDIR      = 4,
  parameter int                DW        = 32,
  parameter logic [NDIR-1:0]   CONNECTED = '1
) (
  input  logic                    op_vld,
  input  logic                    op_send,
  input  logic [$clog2(NDIR)-1:0] op_dir,
  input  logic [NDIR-1:0]         tx_full,
  input  logic [NDIR-1:0]         rx_has,
  input  logic [NDIR*DW-1:0]      rx_data,
  output logic [NDIR-1:0]         tx_wr,
  output logic [NDIR-1:0]         rx_rd,
  output logic                    stall,
  output logic [DW-1:0]           rdata
);
  logic side_live;

  assign side_live = CONNECTED[op_dir];

  always_comb begin
    tx_wr = '0;
    rx_rd = '0;
    stall = 1'b0;
    rdata = '0;
    if (op_vld && side_live) begin
      if (op_send) begin
        if (tx_full[op_dir]) stall = 1'b1;
        else                 tx_wr[op_dir] = 1'b1;
      end else begin
        if (rx_has[op_dir]) begin
          rx_rd[op_dir] = 1'b1;
          rdata         = rx_data[op_dir*DW +: DW];
        end else begin
          stall = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mesh_link_unit.sv
module mesh_link_unit #(
  parameter int              NDIR      = mesh_link_pkg::LINK_SIDES,
  parameter int              DW        = mesh_link_pkg::LINK_WORD_W,
  parameter logic [NDIR-1:0] CONNECTED = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_vld_i,
  input  logic                    op_send_i,
  input  logic [$clog2(NDIR)-1:0] op_dir_i,
  input  logic [DW-1:0]           op_wdata_i,
  output logic                    stall_o,
  output logic [DW-1:0]           op_rdata_o,
  output logic [NDIR*DW-1:0]      tx_data_o,
  output logic [NDIR-1:0]         tx_vld_o,
  input  logic [NDIR-1:0]         tx_room_i,
  input  logic [NDIR*DW-1:0]      rx_data_i,
  input  logic [NDIR-1:0]         rx_vld_i,
  output logic [NDIR-1:0]         rx_room_o
);
  logic [NDIR-1:0]    tx_full, tx_wr, rx_has, rx_rd;
  logic [NDIR*DW-1:0] rx_word;

  mesh_op_decode #(.NDIR(NDIR), .DW(DW), .CONNECTED(CONNECTED)) dec_i (
    .op_vld  (op_vld_i),
    .op_send (op_send_i),
    .op_dir  (op_dir_i),
    .tx_full (tx_full),
    .rx_has  (rx_has),
    .rx_data (rx_word),
    .tx_wr   (tx_wr),
    .rx_rd   (rx_rd),
    .stall   (stall_o),
    .rdata   (op_rdata_o)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_side
    localparam logic LIVE = CONNECTED[d];
    logic          t_vld, r_room, r_has;
    logic [DW-1:0] t_data, r_data;

    mesh_tx_slot #(.DW(DW)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tx_wr[d]),
      .wr_data   (op_wdata_i),
      .full      (tx_full[d]),
      .link_vld  (t_vld),
      .link_data (t_data),
      .link_room (tx_room_i[d] & LIVE)
    );

    mesh_rx_slot #(.DW(DW)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_vld  (rx_vld_i[d] & LIVE),
      .link_data (rx_data_i[d*DW +: DW]),
      .link_room (r_room),
      .rd_en     (rx_rd[d]),
      .has_data  (r_has),
      .rd_data   (r_data)
    );

    assign tx_vld_o[d]             = t_vld & LIVE;
    assign tx_data_o[d*DW +: DW]   = LIVE ? t_data : '0;
    assign rx_room_o[d]            = r_room & LIVE;
    assign rx_has[d]               = r_has & LIVE;
    assign rx_word[d*DW +: DW]     = r_data;
  end
endmodule

// File: rtl/mesh_link_chk.sv
module mesh_link_chk #(
  parameter int              NDIR      = 4,
  parameter int              DW        = 32,
  parameter logic [NDIR-1:0] CONNECTED = '1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_vld_i,
  input logic                    op_send_i,
  input logic [$clog2(NDIR)-1:0] op_dir_i,
  input logic                    stall_o,
  input logic [DW-1:0]           op_rdata_o,
  input logic [NDIR*DW-1:0]      tx_data_o,
  input logic [NDIR-1:0]         tx_vld_o,
  input logic [NDIR-1:0]         tx_room_i,
  input logic [NDIR-1:0]         rx_vld_i,
  input logic [NDIR-1:0]         rx_room_o
);
  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    if (CONNECTED[d]) begin : g_live
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld_o[d] && !tx_room_i[d] |=> tx_vld_o[d] && $stable(tx_data_o[d*DW +: DW]));
      p_rx_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld_i[d] && rx_room_o[d] |=> !rx_room_o[d]);
    end else begin : g_edge
      p_edge_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_vld_o[d] && !rx_room_o[d]);
    end
  end

  p_tx_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld_i && op_send_i && CONNECTED[op_dir_i] && tx_vld_o[op_dir_i] |-> stall_o);
  p_rx_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld_i && !op_send_i && CONNECTED[op_dir_i] && rx_room_o[op_dir_i]
      |-> stall_o && op_rdata_o == '0);
  p_edge_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld_i && !CONNECTED[op_dir_i] |-> !stall_o && op_rdata_o == '0);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld_i |-> !stall_o && op_rdata_o == '0);
endmodule

bind mesh_link_unit mesh_link_chk #(.NDIR(NDIR), .DW(DW), .CONNECTED(CONNECTED)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_vld_i   (op_vld_i),
  .op_send_i  (op_send_i),
  .op_dir_i   (op_dir_i),
  .stall_o    (stall_o),
  .op_rdata_o (op_rdata_o),
  .tx_data_o  (tx_data_o),
  .tx_vld_o   (tx_vld_o),
  .tx_room_i  (tx_room_i),
  .rx_vld_i   (rx_vld_i),
  .rx_room_o  (rx_room_o)
);

// File: tb/mesh_link_unit_tb_top.sv
module mesh_link_unit_tb_top;
  localparam logic [3:0] CONN = 4'b0111;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_vld, op_send;
  logic [1:0]   op_dir;
  logic [31:0]  op_wdata;
  logic         stall;
  logic [31:0]  rdata;
  logic [127:0] tx_data;
  logic [3:0]   tx_vld, tx_room;
  logic [127:0] rx_data;
  logic [3:0]   rx_vld, rx_room;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mesh_link_unit #(.NDIR(4), .DW(32), .CONNECTED(CONN)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_vld_i(op_vld), .op_send_i(op_send),
    .op_dir_i(op_dir), .op_wdata_i(op_wdata), .stall_o(stall), .op_rdata_o(rdata),
    .tx_data_o(tx_data), .tx_vld_o(tx_vld), .tx_room_i(tx_room),
    .rx_data_i(rx_data), .rx_vld_i(rx_vld), .rx_room_o(rx_room)
  );

  localparam logic [33:0] VEC [6] = '{
    {2'd0, 32'hA5A5_0001}, {2'd1, 32'h0000_0000}, {2'd2, 32'hFFFF_FFFF},
    {2'd0, 32'h8000_0001}, {2'd1, 32'h1234_5678}, {2'd2, 32'h0F0F_F0F0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    op_vld = 1'b0; op_send = 1'b0; op_dir = 2'd0; op_wdata = '0;
  endtask

  task automatic set_op(input bit snd, input logic [1:0] d, input logic [31:0] w);
    op_vld = 1'b1; op_send = snd; op_dir = d; op_wdata = w;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); tx_room = '0; rx_vld = '0; rx_data = '0;
    repeat (3) tick();
    check(tx_vld == 4'b0 && stall == 1'b0, "R1 reset tx_vld/stall", {28'd0, tx_vld}, 32'd0);
    check(rx_room == CONN, "R1 reset rx_room", {28'd0, rx_room}, {28'd0, CONN});
    rst_n = 1'b1;
    tick();
    check(rx_room == CONN && tx_vld == 4'b0, "R1 after release", {28'd0, rx_room}, {28'd0, CONN});
    check(!stall && rdata == 0, "R10 idle", rdata, 32'd0);

    for (int i = 0; i < 6; i++) begin
      automatic int d = int'(VEC[i][33:32]);
      automatic logic [31:0] w = VEC[i][31:0];
      set_op(1'b1, VEC[i][33:32], w);
      check(!stall, "R2 send no stall", {31'd0, stall}, 32'd0);
      tick(); idle();
      check(tx_vld[d] && tx_data[d*32 +: 32] == w, "R2 word on link", tx_data[d*32 +: 32], w);
      tick();
      check(tx_vld[d] && tx_data[d*32 +: 32] == w, "R3 held without room", tx_data[d*32 +: 32], w);
      tx_room[d] = 1'b1;
      tick();
      tx_room[d] = 1'b0;
      check(!tx_vld[d], "R3 cleared after transfer", {31'd0, tx_vld[d]}, 32'd0);
      rx_vld[d] = 1'b1; rx_data[d*32 +: 32] = ~w;
      tick();
      rx_vld[d] = 1'b0;
      check(!rx_room[d], "R5 slot filled", {31'd0, rx_room[d]}, 32'd0);
      set_op(1'b0, VEC[i][33:32], '0);
      check(!stall && rdata == ~w, "R6 receive word", rdata, ~w);
      tick(); idle();
      check(rx_room[d], "R6 slot freed", {31'd0, rx_room[d]}, 32'd1);
    end

    // R4: second send into an occupied slot
    set_op(1'b1, 2'd0, 32'h1111_1111); tick();
    set_op(1'b1, 2'd0, 32'h2222_2222);
    check(stall, "R4 stall on full tx", {31'd0, stall}, 32'd1);
    // R9: other side still usable while north is busy
    set_op(1'b1, 2'd1, 32'h3333_3333);
    check(!stall, "R9 east send while north full", {31'd0, stall}, 32'd0);
    tick(); idle();
    check(tx_data[31:0] == 32'h1111_1111, "R4 held word kept", tx_data[31:0], 32'h1111_1111);
    check(tx_vld[1] && tx_data[63:32] == 32'h3333_3333, "R9 east word", tx_data[63:32], 32'h3333_3333);
    tx_room = 4'b0011; tick(); tx_room = '0;
    check(tx_vld == 4'b0, "R3 both drained", {28'd0, tx_vld}, 32'd0);

    // R7: receive from empty slot
    set_op(1'b0, 2'd2, '0);
    check(stall && rdata == 0, "R7 empty rx stall", rdata, 32'd0);
    idle();

    // R5: second inbound word ignored while full
    rx_vld[2] = 1'b1; rx_data[95:64] = 32'hCAFE_0001; tick();
    rx_data[95:64] = 32'hDEAD_0002; tick(); tick();
    rx_vld[2] = 1'b0;
    set_op(1'b0, 2'd2, '0);
    check(rdata == 32'hCAFE_0001, "R5 first word kept", rdata, 32'hCAFE_0001);
    tick(); idle();

    // R8: unconnected west side
    rx_vld[3] = 1'b1; rx_data[127:96] = 32'h7777_7777; tx_room[3] = 1'b1;
    set_op(1'b1, 2'd3, 32'h5555_5555);
    check(!stall, "R8 edge send no stall", {31'd0, stall}, 32'd0);
    tick();
    check(!tx_vld[3] && !rx_room[3], "R8 edge link quiet", {28'd0, tx_vld}, 32'd0);
    set_op(1'b0, 2'd3, '0);
    check(!stall && rdata == 0, "R8 edge receive zero", rdata, 32'd0);
    tick(); idle(); rx_vld = '0; tx_room = '0;
    check(!stall && rdata == 0, "R10 idle end", rdata, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule